// File: doc/BRIEF.md
# Configuration-Space Firmware Loader Target

This block sits on a small configuration-register bus. System software uses it to stream controller firmware into on-chip program storage. Software first opens a load by setting an enable bit in a control byte. It then feeds 32-bit words through two data registers used alternately: the first word of each 8-byte row goes to one register and the second word to the other. After filling a register, software raises that register's ready flag in a separate flag byte. The block hands each flagged word, strictly in alternation, to a valid/ready memory write port at consecutive word addresses. It drops the flag once the word has been taken, and software polls the flag before it refills the register. Because there are two registers, software can fill one while the other waits behind a stalled memory.

Software ends a load by clearing the enable bit. Once every pending word has drained, the block posts a result code (success or error) in the control byte. A sticky lock bit refuses any later load. Enabling again while a load is already open wedges the enable bit on until reset. Reads of the control and flag bytes are combinational on the address.

Top module: `fwload_target`

## Requirements
- R1: After reset the control byte (0xF4) and the flag byte (0xF5) read 0x00 and `mem_valid` is low.
- R2: The control byte reads enable at bit 0, lock at bit 1 and the result code at bits 6:4, with all other bits zero. The flag byte reads the slot-0 flag at bit 0 and the slot-1 flag at bit 1.
- R3: Accepted words leave the memory port alternating slot 0 (0xF8) and slot 1 (0xFC). The address starts at 0 on each load and steps by one per accepted word. `mem_data` equals the dword written, so configuration byte 0 lands in bits 7:0.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R5: A slot flag still reads set in the cycle after the port accepts that slot's word and reads clear from the cycle after that.
- R6: A dword write to a data register whose flag is set is ignored, so both slots can be pending at once with their original words.
- R7: Raising a flag out of alternation order, or on a slot still pending, is ignored (the flag stays clear). The load then finishes with result code 2.
- R8: A byte write of 0xF4 with bit 0 set (with lock and enable clear) opens a load and resets the result to 0. Clearing bit 0 posts result 1 once the pipeline is empty if at least one word was accepted and no order fault occurred, and result 2 otherwise.
- R9: A byte write of 0xF4 with bit 2 set engages the lock. The lock clears only at reset, and while it is set, enable writes are ignored.
- R10: A write setting enable while enable is already set makes enable stick at 1 until reset. After that, disable writes, data writes and flag writes are ignored and no result is posted.
- R11: 0xF4 and 0xF5 react only to byte writes and the data registers only to dword writes. Flag and data writes are ignored while no load is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wr | input | 1 | Write strobe |
| cfg_dword | input | 1 | 1 for a dword write, 0 for a byte write |
| cfg_wdata | input | 32 | Write data; a byte write uses bits 7:0 |
| cfg_rdata | output | 8 | Byte read of the addressed register |
| mem_valid | output | 1 | Word offered to program storage |
| mem_ready | input | 1 | Program storage takes the word |
| mem_addr | output | MEM_AW | Word address of the offered word |
| mem_data | output | 32 | Offered word |

## Verification
The hardest state to reach from the ports has both slots pending behind a stalled memory, with a refill of a pending register arriving in the same window. The bench gets there by holding `mem_ready` low through its ready-pattern generator, writing ahead into both registers and then rewriting the first one, before it lets the port drain. The flag-clear timing is probed on exact clock edges right after a set. Normal loads are swept over every word count from one to six against four distinct backpressure patterns.

// File: rtl/fwload_pkg.sv
package fwload_pkg;
   localparam int WORD_W    = 32;
   localparam int NUM_SLOTS = 2;

   localparam logic [7:0] REG_CTRL = 8'hF4;
   localparam logic [7:0] REG_FLAG = 8'hF5;
   localparam logic [7:0] REG_DAT0 = 8'hF8;
   localparam logic [7:0] REG_DAT1 = 8'hFC;

   localparam int BIT_EN      = 0;
   localparam int BIT_LOCKREQ = 2;

   typedef enum logic [2:0] {
      RES_NONE = 3'd0,
      RES_OK   = 3'd1,
      RES_ERR  = 3'd2
   } load_result_e;
endpackage

// File: rtl/fwload_slot.sv
module fwload_slot
   import fwload_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_word,
   input  logic [WORD_W-1:0] wdata,
   input  logic              set_req,
   input  logic              clr,
   output logic              flag,
   output logic [WORD_W-1:0] word
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         word <= '0;
      end else begin
         if (clr)
            flag <= 1'b0;
         else if (set_req)
            flag <= 1'b1;
         if (wr_word && !flag)
            word <= wdata;
      end
   end
endmodule

// File: rtl/fwload_ctrl.sv
module fwload_ctrl
   import fwload_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_ctrl,
   input  logic         req_en,
   input  logic         req_lock,
   input  logic         pipe_idle,
   input  logic         seq_err,
   input  logic         loaded,
   output logic         en,
   output logic         lock,
   output logic         start,
   output logic         accepting,
   output load_result_e result
);
   logic stale;
   logic closing;

   assign start     = wr_ctrl && req_en && !en && !lock && !closing;
   assign accepting = en && !stale;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en      <= 1'b0;
         lock    <= 1'b0;
         stale   <= 1'b0;
         closing <= 1'b0;
         result  <= RES_NONE;
      end else begin
         if (wr_ctrl && req_lock)
            lock <= 1'b1;
         if (start) begin
            en     <= 1'b1;
            result <= RES_NONE;
         end else if (wr_ctrl && req_en && en) begin
            stale <= 1'b1;
         end else if (wr_ctrl && !req_en && en && !stale) begin
            en      <= 1'b0;
            closing <= 1'b1;
         end
         if (closing && pipe_idle) begin
            closing <= 1'b0;
            result  <= (loaded && !seq_err) ? RES_OK : RES_ERR;
         end
      end
   end

   assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);
   assert_lock_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !en) |=> !en);
   assert_stale_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stale |=> (stale && en));
   assert_post_when_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(result) && result != RES_NONE) |-> (!en && $past(closing)));
endmodule

// File: rtl/fwload_seq.sv
module fwload_seq
   import fwload_pkg::*;
#(
   parameter int MEM_AW         = 14,
   parameter bit MEM_BIG_ENDIAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        set_try,
   input  logic [1:0]        flags,
   input  logic [WORD_W-1:0] words [NUM_SLOTS],
   input  logic              mem_ready,
   output logic [1:0]        set_ok,
   output logic [1:0]        clr,
   output logic              mem_valid,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_data,
   output logic              seq_err,
   output logic              loaded,
   output logic              idle
);
   logic              set_ptr;
   logic              turn;
   logic [1:0]        clr_q;
   logic [MEM_AW-1:0] count;
   logic              bad_set;
   logic              accept;
   logic [WORD_W-1:0] raw;

   always_comb begin
      for (int s = 0; s < NUM_SLOTS; s++)
         set_ok[s] = set_try[s] && (set_ptr == 1'(s)) && !flags[s];
      bad_set = |(set_try & ~set_ok);
   end

   assign mem_valid = flags[turn];
   assign accept    = mem_valid && mem_ready;
   assign raw       = words[turn];
   assign mem_addr  = count;
   assign clr       = clr_q;
   assign idle      = (flags == 2'b00) && (clr_q == 2'b00);

   generate
      if (MEM_BIG_ENDIAN) begin : g_swap
         assign mem_data = {raw[7:0], raw[15:8], raw[23:16], raw[31:24]};
      end else begin : g_pass
         assign mem_data = raw;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_ptr <= 1'b0;
         turn    <= 1'b0;
         clr_q   <= 2'b00;
         count   <= '0;
         seq_err <= 1'b0;
         loaded  <= 1'b0;
      end else begin
         clr_q <= accept ? (turn ? 2'b10 : 2'b01) : 2'b00;
         if (start) begin
            set_ptr <= 1'b0;
            turn    <= 1'b0;
            count   <= '0;
            seq_err <= 1'b0;
            loaded  <= 1'b0;
         end else begin
            if (|set_ok)
               set_ptr <= ~set_ptr;
            if (bad_set)
               seq_err <= 1'b1;
            if (accept) begin
               turn   <= ~turn;
               count  <= count + 1'b1;
               loaded <= 1'b1;
            end
         end
      end
   end

   assert_port_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data) && $stable(mem_addr)));
   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (mem_addr == $past(mem_addr) + 1'b1));
   assert_flag0_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !turn) |=> ##1 !flags[0]);
   assert_flag1_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && turn) |=> ##1 !flags[1]);
endmodule

// File: rtl/fwload_target.sv
module fwload_target
   import fwload_pkg::*;
#(
   parameter int MEM_AW         = 14,
   parameter bit MEM_BIG_ENDIAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        cfg_addr,
   input  logic              cfg_wr,
   input  logic              cfg_dword,
   input  logic [31:0]       cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [31:0]       mem_data
);
   generate
      if (MEM_AW < 1 || MEM_AW > 30) begin : g_bad_aw
         $error("fwload_target: MEM_AW out of range");
      end
   endgenerate

   logic              byte_wr, dword_wr, wr_ctrl, wr_flag;
   logic              en, lock, start, accepting;
   logic              pipe_idle, seq_err, loaded;
   load_result_e      result;
   logic [1:0]        set_try, set_ok, clr, flags;
   logic [NUM_SLOTS-1:0] wr_word;
   logic [WORD_W-1:0] slot_word [NUM_SLOTS];

   assign byte_wr  = cfg_wr && !cfg_dword;
   assign dword_wr = cfg_wr && cfg_dword;
   assign wr_ctrl  = byte_wr && (cfg_addr == REG_CTRL);
   assign wr_flag  = byte_wr && (cfg_addr == REG_FLAG) && accepting;
   assign set_try  = wr_flag ? cfg_wdata[1:0] : 2'b00;
   assign wr_word[0] = dword_wr && (cfg_addr == REG_DAT0) && accepting;
   assign wr_word[1] = dword_wr && (cfg_addr == REG_DAT1) && accepting;

   fwload_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_ctrl),
      .req_en    (cfg_wdata[BIT_EN]),
      .req_lock  (cfg_wdata[BIT_LOCKREQ]),
      .pipe_idle (pipe_idle),
      .seq_err   (seq_err),
      .loaded    (loaded),
      .en        (en),
      .lock      (lock),
      .start     (start),
      .accepting (accepting),
      .result    (result)
   );

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         fwload_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_word (wr_word[s]),
            .wdata   (cfg_wdata),
            .set_req (set_ok[s]),
            .clr     (clr[s]),
            .flag    (flags[s]),
            .word    (slot_word[s])
         );
      end
   endgenerate

   fwload_seq #(
      .MEM_AW         (MEM_AW),
      .MEM_BIG_ENDIAN (MEM_BIG_ENDIAN)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .set_try   (set_try),
      .flags     (flags),
      .words     (slot_word),
      .mem_ready (mem_ready),
      .set_ok    (set_ok),
      .clr       (clr),
      .mem_valid (mem_valid),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .seq_err   (seq_err),
      .loaded    (loaded),
      .idle      (pipe_idle)
   );

   always_comb begin
      case (cfg_addr)
         REG_CTRL: cfg_rdata = {1'b0, result, 2'b00, lock, en};
         REG_FLAG: cfg_rdata = {6'b0, flags};
         default:  cfg_rdata = 8'h00;
      endcase
   end
endmodule

// File: tb/fwload_target_test.sv
module fwload_target_test;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    cfg_addr = 8'h00;
   logic          cfg_wr = 1'b0;
   logic          cfg_dword = 1'b0;
   logic [31:0]   cfg_wdata = 32'h0;
   logic [7:0]    cfg_rdata;
   logic          mem_valid;
   logic          mem_ready = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_data;

   int checks = 0;
   int fails  = 0;
   int rmode  = 0;
   int cyc    = 0;
   int ncap   = 0;
   logic [AW-1:0] cap_addr [64];
   logic [31:0]   cap_data [64];

   fwload_target #(.MEM_AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_dword(cfg_dword), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_data(mem_data)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      cyc = cyc + 1;
      case (rmode)
         0: mem_ready = 1'b1;
         1: mem_ready = cyc[0];
         2: mem_ready = (cyc % 3) == 0;
         3: mem_ready = (cyc % 5) == 4;
         default: mem_ready = 1'b0;
      endcase
   end

   always @(posedge clk) begin
      if (rst_n && mem_valid && mem_ready && ncap < 64) begin
         cap_addr[ncap] = mem_addr;
         cap_data[ncap] = mem_data;
         ncap = ncap + 1;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails = fails + 1;
      $display("FAIL watchdog: run still busy, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
   end

   function automatic logic [31:0] expw(input int run, input int i);
      return (32'h9E3779B9 * (i + 1)) ^ (run << 20);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic peek(input logic [7:0] a, output logic [7:0] v);
      cfg_addr = a;
      #1;
      v = cfg_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit dw);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_dword = dw; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic wait_clear(input logic [7:0] mask);
      logic [7:0] v;
      int t = 0;
      peek(8'hF5, v);
      while ((v & mask) != 0 && t < 500) begin
         @(negedge clk);
         peek(8'hF5, v);
         t++;
      end
   endtask

   task automatic push(input int i, input logic [31:0] d);
      wait_clear(i[0] ? 8'h02 : 8'h01);
      wr(i[0] ? 8'hFC : 8'hF8, d, 1'b1);
      wr(8'hF5, i[0] ? 32'h2 : 32'h1, 1'b0);
   endtask

   task automatic close_load(output logic [7:0] st);
      wait_clear(8'h03);
      wr(8'hF4, 32'h0, 1'b0);
      repeat (4) @(negedge clk);
      peek(8'hF4, st);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      do_reset();
      // R1 reset state, R2 layout
      peek(8'hF4, v); chk("R1 ctrl byte after reset", v, 8'h00);
      peek(8'hF5, v); chk("R1 flag byte after reset", v, 8'h00);
      chk("R1 mem_valid after reset", mem_valid, 1'b0);

      // R3/R8 sweep: word counts 1..6 under four backpressure patterns
      for (int m = 0; m < 4; m++) begin
         for (int n = 1; n <= 6; n++) begin
            rmode = m;
            ncap = 0;
            wr(8'hF4, 32'h1, 1'b0);
            peek(8'hF4, v); chk("R2 enable bit reads back", v, 8'h01);
            for (int i = 0; i < n; i++) push(i, expw(m * 8 + n, i));
            close_load(v);
            chk("R8 success code 1 at bits 6:4", v, 8'h10);
            chk("R3 accepted word count", ncap, n);
            for (int i = 0; i < n; i++) begin
               chk("R3 word address", cap_addr[i], i);
               chk("R3 word data", cap_data[i], expw(m * 8 + n, i));
            end
         end
      end

      // R5 flag clear timing
      rmode = 0; ncap = 0;
      wr(8'hF4, 32'h1, 1'b0);
      wr(8'hF8, 32'h11223344, 1'b1);
      wr(8'hF5, 32'h1, 1'b0);
      @(posedge clk); #2; peek(8'hF5, v);
      chk("R5 flag still set in cycle after accept", v, 8'h01);
      @(posedge clk); #2; peek(8'hF5, v);
      chk("R5 flag clear one cycle later", v, 8'h00);
      close_load(v);
      chk("R8 single word success", v, 8'h10);
      chk("R3 byte 0 in bits 7:0", cap_data[0], 32'h11223344);

      // R6/R4 both slots pending under stall, rewrite ignored
      rmode = 4; ncap = 0;
      wr(8'hF4, 32'h1, 1'b0);
      wr(8'hF8, 32'hAAAA0001, 1'b1);
      wr(8'hF5, 32'h1, 1'b0);
      wr(8'hFC, 32'hBBBB0002, 1'b1);
      wr(8'hF5, 32'h2, 1'b0);
      wr(8'hF8, 32'hCCCC0003, 1'b1);
      peek(8'hF5, v); chk("R6 both slots pending", v, 8'h03);
      repeat (3) @(negedge clk);
      chk("R4 valid held under stall", mem_valid, 1'b1);
      chk("R4 data held under stall", mem_data, 32'hAAAA0001);
      chk("R4 address held under stall", mem_addr, 0);
      rmode = 0;
      close_load(v);
      chk("R6 load result", v, 8'h10);
      chk("R6 word count", ncap, 2);
      chk("R6 first word kept original", cap_data[0], 32'hAAAA0001);
      chk("R6 second word", cap_data[1], 32'hBBBB0002);

      // R7 out-of-turn flag
      ncap = 0;
      wr(8'hF4, 32'h1, 1'b0);
      wr(8'hFC, 32'h55550000, 1'b1);
      wr(8'hF5, 32'h2, 1'b0);
      peek(8'hF5, v); chk("R7 out-of-turn flag ignored", v, 8'h00);
      repeat (2) @(negedge clk);
      chk("R7 nothing emitted", ncap, 0);
      push(0, 32'h0000A000);
      push(1, 32'h0000B000);
      close_load(v);
      chk("R7 error code 2", v, 8'h20);
      chk("R7 in-order words still emitted", ncap, 2);

      // R8 zero-word load, result cleared on open
      wr(8'hF4, 32'h1, 1'b0);
      peek(8'hF4, v); chk("R8 result cleared on open", v, 8'h01);
      close_load(v);
      chk("R8 empty load gives code 2", v, 8'h20);

      // R11 access width and closed-load writes
      wr(8'hF4, 32'h1, 1'b1);
      peek(8'hF4, v); chk("R11 dword write to ctrl ignored", v, 8'h20);
      wr(8'hF5, 32'h1, 1'b0);
      peek(8'hF5, v); chk("R11 flag write with load closed ignored", v, 8'h00);
      chk("R11 no word offered", mem_valid, 1'b0);

      // R9 lock
      wr(8'hF4, 32'h4, 1'b0);
      peek(8'hF4, v); chk("R9 lock engaged", v, 8'h22);
      wr(8'hF4, 32'h1, 1'b0);
      peek(8'hF4, v); chk("R9 enable refused while locked", v, 8'h22);
      wr(8'hF4, 32'h0, 1'b0);
      peek(8'hF4, v); chk("R9 lock sticky", v, 8'h22);
      do_reset();
      peek(8'hF4, v); chk("R1 R9 reset clears lock", v, 8'h00);

      // R10 stale enable
      ncap = 0;
      wr(8'hF4, 32'h1, 1'b0);
      wr(8'hF4, 32'h1, 1'b0);
      wr(8'hF4, 32'h0, 1'b0);
      repeat (4) @(negedge clk);
      peek(8'hF4, v); chk("R10 enable stuck, no result", v, 8'h01);
      wr(8'hF8, 32'h12345678, 1'b1);
      wr(8'hF5, 32'h1, 1'b0);
      peek(8'hF5, v); chk("R10 flag write ignored", v, 8'h00);
      repeat (3) @(negedge clk);
      chk("R10 nothing emitted", ncap, 0);
      do_reset();
      peek(8'hF4, v); chk("R1 R10 reset clears stale enable", v, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule